// File: doc/BRIEF.md
# Source Address Priority Classifier

This block assigns a priority class to a packet from its 32-bit source IP address. A table of associative entries holds an address value, a per-bit care mask and a live flag. Every live entry compares its stored value against the lookup key on the bits its mask selects. The index of the winning entry then addresses a separate class table, and the class read from there is the block's answer.

Management logic loads the tables through a write port. The entry table and the class table have their own write enables and share one index. The datapath presents one key per cycle with a request strobe. Each result comes back two cycles later with a valid flag, a hit flag, the winning index and the class. A mask that clears the low eight bits lets one entry cover a whole /24 range.

Top module: `srcaddr_classifier`

## Requirements
- R1: After reset, res_valid and res_hit are low and every entry is not live, so no lookup hits until an entry is written live.
- R2: A request sampled with lk_valid high at clock edge k produces res_valid high after edge k+1. A new request is accepted on every cycle, and the results come back in request order.
- R3: A live entry matches when the key equals its stored value on every bit whose care mask bit is 1. With an all-ones mask, only the exact address matches.
- R4: An entry with care mask 0xFFFFFF00 matches every address that shares its upper 24 bits, whatever the final octet holds.
- R5: When several live entries match, the lowest index wins, and res_idx reports that index.
- R6: When no live entry matches, res_hit is 0, res_idx is 0 and res_class is the default class, low (2'b00).
- R7: On a hit, res_class is the class table word at the winning index. The encoding is 2'b00 low, 2'b01 medium and 2'b10 high.
- R8: An entry written with wr_live low never matches, even if its value and mask would match the key.
- R9: An entry write takes effect for lookups issued in a later cycle. A lookup issued in the same cycle as an entry write matches against the previous contents of that entry.
- R10: A cycle with lk_valid low produces no result: res_valid stays low two cycles later and res_hit stays low with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Write the entry at wr_idx with wr_addr, wr_care and wr_live |
| cls_we | input | 1 | Write wr_class into the class table at wr_idx |
| wr_idx | input | 4 | Index of the table slot to write |
| wr_addr | input | 32 | Address value to store in the entry |
| wr_care | input | 32 | Care mask; a 1 bit takes part in the comparison |
| wr_live | input | 1 | Live flag to store in the entry |
| wr_class | input | 2 | Class to store in the class table |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Source address to classify |
| res_valid | output | 1 | Result valid, two cycles after the request |
| res_hit | output | 1 | At least one live entry matched |
| res_idx | output | 4 | Index of the winning entry, 0 on a miss |
| res_class | output | 2 | Class of the winning entry, or low on a miss |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request, and that wr_live carries a known value whenever ent_we is high. The empty-table check depends on this: it treats any hit before the first live write as an error. The bench drives every input on the falling edge and holds all write enables low except in single-cycle write pulses. It writes an entry in the same cycle as a request only in the one scenario built to test that ordering.

// File: rtl/srcaddr_classifier.sv
module srcaddr_classifier #(
  parameter int ENTRIES   = 16,
  parameter int AW        = 32,
  parameter int CW        = 2,
  parameter int DEF_CLASS = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ent_we,
  input  logic                         cls_we,
  input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
  input  logic [AW-1:0]                wr_addr,
  input  logic [AW-1:0]                wr_care,
  input  logic                         wr_live,
  input  logic [CW-1:0]                wr_class,
  input  logic                         lk_valid,
  input  logic [AW-1:0]                lk_addr,
  output logic                         res_valid,
  output logic                         res_hit,
  output logic [$clog2(ENTRIES)-1:0]   res_idx,
  output logic [CW-1:0]                res_class
);
  localparam int IW = $clog2(ENTRIES);

  logic [AW-1:0] ent_val  [ENTRIES];
  logic [AW-1:0] ent_care [ENTRIES];
  logic [ENTRIES-1:0] ent_live;
  logic [CW-1:0] cls_ram  [ENTRIES];

  logic [ENTRIES-1:0] hv;
  logic               m_hit;
  logic [IW-1:0]      m_idx;

  logic               s1_v, s1_hit;
  logic [IW-1:0]      s1_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_live <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_val[i]  <= '0;
        ent_care[i] <= '0;
        cls_ram[i]  <= CW'(DEF_CLASS);
      end
    end else begin
      if (ent_we) begin
        ent_val[wr_idx]  <= wr_addr;
        ent_care[wr_idx] <= wr_care;
        ent_live[wr_idx] <= wr_live;
      end
      if (cls_we) cls_ram[wr_idx] <= wr_class;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hv[g] = ent_live[g] && (((lk_addr ^ ent_val[g]) & ent_care[g]) == '0);
  end

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) begin
        m_hit = 1'b1;
        m_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_hit <= 1'b0;
      s1_idx <= '0;
    end else begin
      s1_v   <= lk_valid;
      s1_hit <= lk_valid && m_hit;
      s1_idx <= m_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_class <= CW'(DEF_CLASS);
    end else begin
      res_valid <= s1_v;
      res_hit   <= s1_v && s1_hit;
      if (s1_v) begin
        res_idx   <= s1_hit ? s1_idx : '0;
        res_class <= s1_hit ? cls_ram[s1_idx] : CW'(DEF_CLASS);
      end
    end
  end
endmodule

// File: rtl/srcaddr_classifier_chk.sv
module srcaddr_classifier_chk #(
  parameter int IW        = 4,
  parameter int CW        = 2,
  parameter int DEF_CLASS = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ent_we,
  input logic          wr_live,
  input logic          lk_valid,
  input logic          res_valid,
  input logic          res_hit,
  input logic [IW-1:0] res_idx,
  input logic [CW-1:0] res_class
);
  logic d1, d2, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= 1'b0; d2 <= 1'b0; armed <= 1'b0;
    end else begin
      d1 <= lk_valid;
      d2 <= d1;
      if (ent_we && wr_live) armed <= 1'b1;
    end
  end

  // R2 R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid == d2);

  // R6
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_class == CW'(DEF_CLASS) && res_idx == '0));

  // R10
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) res_hit |-> res_valid);

  // R1
  empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> !res_hit);

  // R2
  known_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown({res_valid, res_hit}));
endmodule

bind srcaddr_classifier srcaddr_classifier_chk #(.IW(IW), .CW(CW), .DEF_CLASS(DEF_CLASS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .wr_live(wr_live), .lk_valid(lk_valid),
  .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_class(res_class)
);

// File: tb/srcaddr_classifier_tb_top.sv
module srcaddr_classifier_tb_top;
  logic clk = 0, rst_n = 0;
  logic ent_we = 0, cls_we = 0, wr_live = 0, lk_valid = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_addr = 0, wr_care = 0, lk_addr = 0;
  logic [1:0] wr_class = 0;
  logic res_valid, res_hit;
  logic [3:0] res_idx;
  logic [1:0] res_class;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_val [16];
  logic [31:0] m_care [16];
  bit          m_live [16];
  logic [1:0]  m_cls [16];

  always #4 clk = ~clk;

  srcaddr_classifier dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] k, output bit h, output int idx, output int cls);
    h = 0; idx = 0; cls = 0;
    for (int i = 15; i >= 0; i--)
      if (m_live[i] && (((k ^ m_val[i]) & m_care[i]) == 0)) begin h = 1; idx = i; cls = m_cls[i]; end
  endfunction

  task automatic put(input int i, input logic [31:0] a, input logic [31:0] c, input bit lv, input logic [1:0] cl);
    @(negedge clk);
    ent_we = 1; cls_we = 1; wr_idx = 4'(i); wr_addr = a; wr_care = c; wr_live = lv; wr_class = cl;
    @(negedge clk);
    ent_we = 0; cls_we = 0;
    m_val[i] = a; m_care[i] = c; m_live[i] = lv; m_cls[i] = cl;
  endtask

  task automatic check_res(input logic [31:0] k, input string req);
    bit h; int idx, cls;
    model(k, h, idx, cls);
    chk(res_valid === 1'b1, req, "valid", int'(res_valid), 1);
    chk(res_hit === h, req, "hit", int'(res_hit), int'(h));
    chk(res_idx === 4'(idx), req, "idx", int'(res_idx), idx);
    chk(res_class === 2'(cls), req, "class", int'(res_class), cls);
  endtask

  task automatic look(input logic [31:0] k, input string req);
    @(negedge clk); lk_valid = 1; lk_addr = k;
    @(negedge clk); lk_valid = 0;
    @(negedge clk); check_res(k, req);
  endtask

  task automatic t_reset;
    chk(res_valid === 0 && res_hit === 0, "R1", "reset outputs", int'({res_valid, res_hit}), 0);
    look(32'hC0A8_0101, "R1");
    chk(res_hit === 0, "R1", "empty table hit", int'(res_hit), 0);
  endtask

  task automatic t_exact;
    put(5, 32'hC019_1B1C, 32'hFFFF_FFFF, 1, 2'b10);
    look(32'hC019_1B1C, "R3");
    chk(res_hit === 1 && res_class === 2'b10, "R7", "exact high", int'(res_class), 2);
    look(32'hC019_1B1D, "R3");
  endtask

  task automatic t_wild;
    put(7, 32'hC019_1600, 32'hFFFF_FF00, 1, 2'b00);
    put(9, 32'hC001_0577, 32'hFFFF_FFFF, 1, 2'b01);
    look(32'hC019_1642, "R4");
    look(32'hC019_16FF, "R4");
    look(32'hC019_1742, "R4");
    look(32'hC001_0577, "R7");
  endtask

  task automatic t_prio;
    put(2, 32'hC019_1600, 32'hFFFF_0000, 1, 2'b01);
    look(32'hC019_1642, "R5");
    chk(res_idx === 4'd2, "R5", "lowest index", int'(res_idx), 2);
    look(32'hC019_1B1C, "R5");
  endtask

  task automatic t_miss;
    look(32'h0A00_0001, "R6");
    chk(res_class === 2'b00 && res_idx === 0, "R6", "default", int'(res_class), 0);
  endtask

  task automatic t_dead;
    put(1, 32'h0A00_0001, 32'hFFFF_FFFF, 0, 2'b10);
    look(32'h0A00_0001, "R8");
    chk(res_hit === 0, "R8", "not live", int'(res_hit), 0);
  endtask

  task automatic t_pipe;
    logic [31:0] ks [4] = '{32'hC019_1B1C, 32'h0A00_0001, 32'hC001_0577, 32'hC019_1610};
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c >= 2) check_res(ks[c-2], "R2");
      if (c < 4) begin lk_valid = 1; lk_addr = ks[c]; end else lk_valid = 0;
    end
    @(negedge clk);
    chk(res_valid === 0, "R10", "idle no result", int'(res_valid), 0);
  endtask

  task automatic t_same;
    @(negedge clk);
    ent_we = 1; wr_idx = 4'd0; wr_addr = 32'h0B0B_0B0B; wr_care = 32'hFFFF_FFFF; wr_live = 1;
    lk_valid = 1; lk_addr = 32'h0B0B_0B0B;
    @(negedge clk);
    ent_we = 0; lk_valid = 0;
    @(negedge clk);
    chk(res_valid === 1 && res_hit === 0, "R9", "same-cycle old entry", int'(res_hit), 0);
    m_val[0] = 32'h0B0B_0B0B; m_care[0] = 32'hFFFF_FFFF; m_live[0] = 1;
    look(32'h0B0B_0B0B, "R9");
    chk(res_hit === 1 && res_idx === 0, "R9", "later lookup sees write", int'(res_hit), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_care[i] = 0; m_live[i] = 0; m_cls[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_exact; t_wild; t_prio; t_miss; t_dead; t_pipe; t_same;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule